// File: doc/BRIEF.md
# Streaming Vector Aggregator

This block sums integer update vectors sent by a fixed group of workers. It keeps a small pool of aggregator slots. Each slot holds K_ELEMS accumulators, a record of which workers have contributed, and a contribution count. An update names a slot, a worker and a vector of K_ELEMS signed integers. The block adds that vector, element by element, into the named slot. When every worker has contributed once, the slot presents its summed vector on the result port. The result carries the same slot index and a mask that asks for one copy per worker.

A model vector is much longer than K_ELEMS. The workers therefore stream it through the pool one chunk at a time. When a result beat is taken, the slot clears in that same cycle and can start on the next chunk. Updates for different slots may arrive in any interleaving. An update that names a slot whose result is still waiting is held off by deasserting ready.

Top module: `vec_agg_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `res_valid` is 0 and `up_ready` is 1 for every slot index.
- R2: An accepted update adds lane i of `up_data` (bits i*ELEM_W and up) into lane i of the slot selected by `up_slot`. Other slots are unchanged. The first contribution to an empty slot loads the vector as it stands.
- R3: A slot raises its result only after N_WORKERS distinct worker IDs have contributed to the current chunk.
- R4: A repeated update from a worker that has already contributed to the current chunk is accepted but adds nothing.
- R5: A result beat carries the slot index in `res_slot` and the summed vector in `res_data`. `res_bcast` is all ones, where bit w stands for worker w.
- R6: In the cycle a result beat is taken (`res_valid` and `res_ready`), that slot's sums, record and count return to zero. The next chunk in that slot therefore starts from zero.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_slot` and `res_data` hold their values into the next cycle.
- R8: `up_ready` is 0 exactly when the slot named by `up_slot` has a result waiting.
- R9: When a new result beat is chosen and several slots are complete, the lowest slot index is presented first.
- R10: Sums wrap modulo 2^ELEM_W. There is no saturation.
- R11: `res_valid` rises in the cycle after the edge that accepts the last missing contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Update offered |
| up_ready | output | 1 | Update can be taken |
| up_slot | input | clog2(N_SLOTS) | Aggregator slot index |
| up_worker | input | clog2(N_WORKERS) | Contributing worker ID |
| up_data | input | K_ELEMS*ELEM_W | Signed lanes, lane 0 in the low bits |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Downstream takes the result |
| res_slot | output | clog2(N_SLOTS) | Slot the result belongs to |
| res_data | output | K_ELEMS*ELEM_W | Summed lanes |
| res_bcast | output | N_WORKERS | Delivery mask, one bit per worker |

## Verification
The assertions assume that `up_slot` and `up_worker` name existing slots and workers. They also assume that the downstream side may stall for any number of cycles. The bench picks slot and worker IDs only from the legal ranges. It toggles `res_ready` at random and with long stalls, so the hold and blocking rules are exercised under back-pressure. Duplicate updates, extreme values that force wrapping, and several slots completing at once all come from the stimulus and not from assumptions.

// File: rtl/vagg_pkg.sv
// Shared helpers for the vector aggregator.
// Assumes nothing beyond positive parameter values.
package vagg_pkg;
    // Width of an index that addresses n items (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/vagg_lane.sv
// One accumulator lane: loads, adds or clears a single vector element.
// Assumes clr and en are never both needed in the same cycle (clr wins).
module vagg_lane #(
    parameter int ELEM_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              load,
    input  logic [ELEM_W-1:0] din,
    output logic [ELEM_W-1:0] acc
);
    // Accumulate with wrap-around; load on first contribution; zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= load ? din : acc + din;
        end
    end
endmodule

// File: rtl/vagg_slot.sv
// One aggregator slot: K_ELEMS lanes, a per-worker record and a count.
// Raises done once every worker has contributed; repeats are dropped.
// Assumes wr_en is never asserted while done is high (top gates it).
module vagg_slot
    import vagg_pkg::*;
#(
    parameter int N_WORKERS = 4,
    parameter int K_ELEMS   = 8,
    parameter int ELEM_W    = 32,
    localparam int WID_W    = idx_width(N_WORKERS),
    localparam int VEC_W    = K_ELEMS * ELEM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WID_W-1:0] wr_worker,
    input  logic [VEC_W-1:0] wr_data,
    input  logic             clr,
    output logic             done,
    output logic [VEC_W-1:0] acc
);
    localparam int CNT_W = $clog2(N_WORKERS + 1);

    logic [N_WORKERS-1:0] seen_map;
    logic [CNT_W-1:0]     cnt;
    logic                 worker_ok;
    logic                 already;
    logic                 add_en;
    logic                 first;

    // Decide whether this update counts: a legal worker not yet seen.
    always_comb begin
        worker_ok = int'(wr_worker) < N_WORKERS;
        already   = worker_ok ? seen_map[wr_worker] : 1'b1;
        add_en    = wr_en && !already;
        first     = (cnt == '0);
    end

    // One lane per vector element.
    for (genvar i = 0; i < K_ELEMS; i++) begin : g_lane
        vagg_lane #(.ELEM_W(ELEM_W)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .en   (add_en),
            .load (first),
            .din  (wr_data[i*ELEM_W +: ELEM_W]),
            .acc  (acc[i*ELEM_W +: ELEM_W])
        );
    end

    // Track contributors and flag completion; clear with the lanes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen_map <= '0;
            cnt      <= '0;
            done     <= 1'b0;
        end else if (add_en) begin
            seen_map[wr_worker] <= 1'b1;
            cnt                 <= cnt + 1'b1;
            done                <= (cnt == CNT_W'(N_WORKERS - 1));
        end
    end
endmodule

// File: rtl/vagg_pick.sv
// Result selector: picks the lowest-index complete slot and keeps that
// choice locked while the downstream side stalls.
// Assumes a requested slot stays requested until it is acknowledged.
module vagg_pick #(
    parameter int N_REQ = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req,
    input  logic             ack,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic             lock_q;
    logic [IDX_W-1:0] lock_idx;
    logic [IDX_W-1:0] lowest;

    // Lowest set request wins a fresh choice.
    always_comb begin
        lowest = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i]) lowest = IDX_W'(i);
        end
    end

    // Present the locked slot if stalled, otherwise the fresh choice.
    always_comb begin
        any = lock_q || (|req);
        idx = lock_q ? lock_idx : lowest;
    end

    // Lock the presented slot for as long as it is not taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= 1'b0;
            lock_idx <= '0;
        end else begin
            lock_q   <= any && !ack;
            lock_idx <= idx;
        end
    end
endmodule

// File: rtl/vec_agg_top.sv
// Streaming vector aggregator top: routes updates to slots, blocks updates
// to slots whose result waits, and presents completed sums one at a time.
// Assumes slot and worker IDs come from trusted senders; out-of-range slot
// indices are accepted and dropped.
module vec_agg_top
    import vagg_pkg::*;
#(
    parameter int N_WORKERS = 4,
    parameter int K_ELEMS   = 8,
    parameter int ELEM_W    = 32,
    parameter int N_SLOTS   = 4,
    localparam int SLOT_W   = idx_width(N_SLOTS),
    localparam int WID_W    = idx_width(N_WORKERS),
    localparam int VEC_W    = K_ELEMS * ELEM_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 up_valid,
    output logic                 up_ready,
    input  logic [SLOT_W-1:0]    up_slot,
    input  logic [WID_W-1:0]     up_worker,
    input  logic [VEC_W-1:0]     up_data,
    output logic                 res_valid,
    input  logic                 res_ready,
    output logic [SLOT_W-1:0]    res_slot,
    output logic [VEC_W-1:0]     res_data,
    output logic [N_WORKERS-1:0] res_bcast
);
    logic [N_SLOTS-1:0] pend;
    logic [VEC_W-1:0]   slot_acc [N_SLOTS];
    logic [SLOT_W-1:0]  pick_idx;
    logic               pick_any;
    logic               slot_ok;
    logic               accept;
    logic               take;

    // Handshake on the update side: stall only a slot with a waiting result.
    always_comb begin
        slot_ok  = int'(up_slot) < N_SLOTS;
        up_ready = slot_ok ? !pend[up_slot] : 1'b1;
        accept   = up_valid && up_ready && slot_ok;
    end

    // Choose which completed slot to present.
    vagg_pick #(.N_REQ(N_SLOTS), .IDX_W(SLOT_W)) u_pick (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (pend),
        .ack  (res_ready),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    // Drive the result beat from the chosen slot.
    always_comb begin
        res_valid = pick_any;
        res_slot  = pick_idx;
        res_data  = slot_acc[pick_idx];
        res_bcast = {N_WORKERS{pick_any}};
        take      = pick_any && res_ready;
    end

    // The slot pool.
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        vagg_slot #(
            .N_WORKERS(N_WORKERS),
            .K_ELEMS  (K_ELEMS),
            .ELEM_W   (ELEM_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (accept && (up_slot == SLOT_W'(s))),
            .wr_worker(up_worker),
            .wr_data  (up_data),
            .clr      (take && (pick_idx == SLOT_W'(s))),
            .done     (pend[s]),
            .acc      (slot_acc[s])
        );
    end
endmodule

// File: rtl/vec_agg_checker.sv
// Protocol checker for vec_agg_top, bound to every instance.
// Assumes legal slot and worker IDs on the update port.
module vec_agg_checker #(
    parameter int N_WORKERS = 4,
    parameter int SLOT_W    = 2,
    parameter int VEC_W     = 256
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 up_valid,
    input logic                 up_ready,
    input logic [SLOT_W-1:0]    up_slot,
    input logic                 res_valid,
    input logic                 res_ready,
    input logic [SLOT_W-1:0]    res_slot,
    input logic [VEC_W-1:0]     res_data,
    input logic [N_WORKERS-1:0] res_bcast
);
    // R7: a stalled beat keeps its slot and data.
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_slot) && $stable(res_data)));

    // R8: the slot being presented cannot take a new update.
    a_r8_block_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && up_slot == res_slot) |-> !up_ready);

    // R5: every result beat is addressed to all workers.
    a_r5_bcast_all: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (&res_bcast));

    // R6: a taken slot is not presented again in the next cycle.
    a_r6_cleared_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready) |=> !(res_valid && res_slot == $past(res_slot)));
endmodule

bind vec_agg_top vec_agg_checker #(
    .N_WORKERS(N_WORKERS),
    .SLOT_W   (SLOT_W),
    .VEC_W    (VEC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (up_valid),
    .up_ready (up_ready),
    .up_slot  (up_slot),
    .res_valid(res_valid),
    .res_ready(res_ready),
    .res_slot (res_slot),
    .res_data (res_data),
    .res_bcast(res_bcast)
);

// File: tb/vec_agg_top_test.sv
`timescale 1ns/1ps
module vec_agg_top_test;
    localparam int NW = 4, K = 8, W = 32, NS = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           up_valid = 1'b0;
    logic           up_ready;
    logic [1:0]     up_slot = '0;
    logic [1:0]     up_worker = '0;
    logic [K*W-1:0] up_data = '0;
    logic           res_valid;
    logic           res_ready = 1'b1;
    logic [1:0]     res_slot;
    logic [K*W-1:0] res_data;
    logic [NW-1:0]  res_bcast;

    int checks = 0, fails = 0, cyc = 0;

    always #2.5 clk = ~clk;

    vec_agg_top uut (.*);

    // Reference model state
    logic [W-1:0]  m_sum [NS][K];
    logic [NW-1:0] m_map [NS];
    bit            m_done [NS];
    bit            m_lock;
    int            m_lock_slot;
    int            p;
    bit            acc;

    function automatic int pres_slot();
        if (m_lock) return m_lock_slot;
        for (int s = 0; s < NS; s++) if (m_done[s]) return s;
        return -1;
    endfunction

    task automatic clear_slot(input int s);
        for (int k = 0; k < K; k++) m_sum[s][k] = '0;
        m_map[s]  = '0;
        m_done[s] = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) clear_slot(s);
            m_lock = 1'b0;
            m_lock_slot = 0;
        end else begin
            p   = pres_slot();
            acc = up_valid && !m_done[up_slot];
            if (p >= 0 && res_ready) clear_slot(p);
            if (acc && !m_map[up_slot][up_worker]) begin
                for (int k = 0; k < K; k++)
                    m_sum[up_slot][k] = m_sum[up_slot][k] + up_data[k*W +: W];
                m_map[up_slot][up_worker] = 1'b1;
                if (&m_map[up_slot]) m_done[up_slot] = 1'b1;
            end
            m_lock      = (p >= 0) && !res_ready;
            m_lock_slot = p;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [K*W-1:0] act,
                       input logic [K*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Compare every output against the model; called between edges.
    task automatic compare();
        int ps;
        logic [K*W-1:0] ev;
        ps = pres_slot();
        chk(res_valid == (ps >= 0), "R3 R11 res_valid", K*W'(res_valid), K*W'(ps >= 0));
        chk(up_ready == !m_done[up_slot], "R8 up_ready", K*W'(up_ready), K*W'(!m_done[up_slot]));
        if (ps >= 0) begin
            for (int k = 0; k < K; k++) ev[k*W +: W] = m_sum[ps][k];
            chk(res_slot == ps[1:0], "R9 R7 res_slot", K*W'(res_slot), K*W'(ps));
            chk(res_data == ev, "R2 R4 R6 R10 res_data", res_data, ev);
            chk(res_bcast == '1, "R5 res_bcast", K*W'(res_bcast), K*W'(4'hf));
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    // kind 0: random, 1: max positive (wrap), 2: small pattern
    task automatic put(input bit v, input int s, input int w, input int kind);
        up_valid  = v;
        up_slot   = s[1:0];
        up_worker = w[1:0];
        for (int k = 0; k < K; k++)
            up_data[k*W +: W] = (kind == 0) ? W'($urandom) :
                                (kind == 1) ? 32'h7fff_ffff : W'(w * 16 + k + 1);
        tick();
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0, "R1 res_valid in reset", K*W'(res_valid), '0);
        chk(up_ready == 1'b1, "R1 up_ready in reset", K*W'(up_ready), K*W'(1));
        rst_n = 1'b1;
        tick();
        chk(res_valid == 1'b0, "R1 res_valid after reset", K*W'(res_valid), '0);

        // R2 R3 R4 R11: slot 0 with a repeated worker 1 mid-chunk
        put(1, 0, 0, 2);
        put(1, 0, 1, 2);
        put(1, 0, 1, 0);  // R4 duplicate, random data must not add
        put(1, 0, 2, 2);
        put(1, 0, 3, 2);
        put(0, 0, 0, 2);
        // R10: wrapping sums in slot 1
        for (int w = 0; w < NW; w++) put(1, 1, w, 1);
        put(0, 0, 0, 2);
        // R6: next chunk in slot 0 starts from zero
        for (int w = 0; w < NW; w++) put(1, 0, w, 0);
        put(0, 0, 0, 2);

        // R7 R8 R9: stall while slots 3, 2, 0 complete
        res_ready = 1'b0;
        for (int w = 0; w < NW; w++) put(1, 3, w, 0);
        for (int w = 0; w < NW; w++) put(1, 2, w, 0);
        for (int w = 0; w < NW; w++) put(1, 0, w, 0);
        put(1, 3, 0, 0);   // R8 blocked
        put(1, 1, 2, 0);   // other slot still accepted
        repeat (4) put(0, 0, 0, 0);
        res_ready = 1'b1;
        repeat (6) put(0, 0, 0, 0);

        // Random traffic with back-pressure
        for (int i = 0; i < 4000; i++) begin
            res_ready = ($urandom % 10) < 7;
            put(($urandom % 10) < 7, $urandom % NS, $urandom % NW,
                (($urandom % 8) == 0) ? 1 : 0);
        end
        up_valid = 1'b0;
        res_ready = 1'b1;
        repeat (8) tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cyc == 150000);
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule